// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a 32-bit processor core that finishes every instruction within one clock cycle. It runs nine instructions: word load and word store, register add, subtract, AND, OR and signed set-less-than, branch-if-equal and an unconditional jump. The program counter addresses an internal instruction array. Two register-file reads feed one ALU, which computes the effective address for memory instructions, the result for arithmetic instructions and the equality test for branches. A data array serves loads and stores. All state changes on the rising clock edge.

While the core is held in reset, a testbench or a boot agent fills the instruction array and the data array through one preload port. After reset is released, execution starts at address 0. The debug outputs show the current program counter and the register-file write port. The write port view shows every register write at the moment it is committed, so a host can follow the instruction stream cycle by cycle.

Top module: `core_top`

## Requirements
- R1: `dbg_pc` resets to 0. After each rising edge outside reset, it holds the old PC plus 4, unless a taken branch or a jump redirects it.
- R2: An R-type instruction (opcode 0) with function code 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt to register rd. Here rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11.
- R3: Function code 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R4: Load (opcode 0x23) and store (opcode 0x2B) form the address as rs plus the sign-extended 16-bit field in bits 15:0. The data array is indexed by address bits 7:2. A load writes the word to rt. A store writes rt's value to the array and makes no register write.
- R5: Branch-if-equal (opcode 0x04) sets the next PC to PC+4 plus the sign-extended offset shifted left by 2 when rs equals rt, and to PC+4 otherwise.
- R6: Jump (opcode 0x02) sets the next PC to bits 31:28 of PC+4 joined to bits 25:0 of the instruction shifted left by 2.
- R7: Register 0 always reads as zero. A write aimed at it changes nothing and does not raise `dbg_wr_en`.
- R8: While `rst_n` is low, `dbg_pc` is 0, `dbg_wr_en` is 0 and every register reads as zero.
- R9: A preload write with `load_we` high stores `load_data` at word `load_addr`. The target is the data array when `load_dmem` is 1 and the instruction array when it is 0. The instruction array is indexed by PC bits 7:2.
- R10: Any other opcode, or an R-type instruction with any other function code, writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with the clock |
| load_we | input | 1 | Preload write strobe |
| load_dmem | input | 1 | Preload target: 1 selects the data array, 0 selects the instruction array |
| load_addr | input | LOAD_AW (6) | Preload word index |
| load_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | A register write commits at the next edge |
| dbg_wr_addr | output | 5 | Register being written |
| dbg_wr_data | output | 32 | Value being written |

## Verification
A bad register value stays hidden until an instruction reads it. It then shows up in that instruction's `dbg_wr_data` in the same cycle, or as a wrong `dbg_pc` one cycle after a branch that compares it. A bad data-array word shows up only when a later load of that word reaches the write port. For this reason the bench follows every store with loads of the same address, and it compares the PC and the write port in every cycle. A wrong next-PC computation appears in `dbg_pc` after one edge.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    mem_to_reg;
    logic    mem_we;
    logic    alu_imm;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/core_decoder.sv
module core_decoder
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_we     = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.alu_imm    = 1'b1;
      end
      OP_STORE: begin
        ctrl.mem_we  = 1'b1;
        ctrl.alu_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] result,
  output logic             is_zero
);

  always_comb begin
    unique case (op)
      ALU_AND: result = op_a & op_b;
      ALU_OR:  result = op_a | op_b;
      ALU_ADD: result = op_a + op_b;
      ALU_SUB: result = op_a - op_b;
      ALU_SLT: result = {{(WIDTH-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
      default: result = '0;
    endcase
  end

  assign is_zero = (result == '0);

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int WIDTH   = 32,
  parameter int ADDR_W  = 5,
  localparam int NREGS  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [WIDTH-1:0]  rd_data_a,
  output logic [WIDTH-1:0]  rd_data_b
);

  logic [WIDTH-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en && (wr_addr != '0)) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = (rd_addr_a == '0) ? '0 : regs[rd_addr_a];
  assign rd_data_b = (rd_addr_b == '0) ? '0 : regs[rd_addr_b];

endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
#(
  parameter int IMEM_AW  = 6,
  parameter int DMEM_AW  = 6,
  localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_we,
  input  logic               load_dmem,
  input  logic [LOAD_AW-1:0] load_addr,
  input  logic [31:0]        load_data,
  output logic [31:0]        dbg_pc,
  output logic               dbg_wr_en,
  output logic [4:0]         dbg_wr_addr,
  output logic [31:0]        dbg_wr_data
);

  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] pc, pc_next, pc_plus4, br_target, j_target;
  logic [31:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, dmem_rdata, wb_data;
  logic [4:0]  wb_addr;
  logic        alu_zero, store_en;
  ctrl_t       ctrl;

  // instruction fetch
  assign instr = imem[pc[IMEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (load_we && !load_dmem) imem[load_addr[IMEM_AW-1:0]] <= load_data;
  end

  core_decoder u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign wb_addr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_y;

  core_regfile #(.WIDTH(32), .ADDR_W(5)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl.reg_we),
    .wr_addr   (wb_addr),
    .wr_data   (wb_data),
    .rd_addr_a (instr[25:21]),
    .rd_addr_b (instr[20:16]),
    .rd_data_a (rs_val),
    .rd_data_b (rt_val)
  );

  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.alu_imm ? imm_ext : rt_val;

  core_alu #(.WIDTH(32)) u_alu (
    .op_a    (rs_val),
    .op_b    (alu_b),
    .op      (ctrl.alu_op),
    .result  (alu_y),
    .is_zero (alu_zero)
  );

  // data memory: preload has priority, stores only outside reset
  assign dmem_rdata = dmem[alu_y[DMEM_AW+1:2]];
  assign store_en   = ctrl.mem_we && rst_n;

  always_ff @(posedge clk) begin
    if (load_we && load_dmem) begin
      dmem[load_addr[DMEM_AW-1:0]] <= load_data;
    end else if (store_en) begin
      dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
    end
  end

  // next-PC selection
  assign pc_plus4  = pc + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                   pc_next = j_target;
    else if (ctrl.branch && alu_zero) pc_next = br_target;
    else                             pc_next = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  assign dbg_pc      = pc;
  assign dbg_wr_en   = ctrl.reg_we && rst_n && (wb_addr != 5'd0);
  assign dbg_wr_addr = wb_addr;
  assign dbg_wr_data = wb_data;

endmodule

// File: rtl/core_checks.sv
module core_checks
  import core_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] dbg_pc,
  input logic        dbg_wr_en,
  input logic [4:0]  dbg_wr_addr,
  input logic [31:0] dbg_wr_data,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);

  logic [5:0]  op, fn;
  logic [31:0] seq_pc, br_pc, jmp_pc;
  logic        known_op;

  assign op       = instr[31:26];
  assign fn       = instr[5:0];
  assign seq_pc   = dbg_pc + 32'd4;
  assign br_pc    = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_pc   = {seq_pc[31:28], instr[25:0], 2'b00};
  assign known_op = (op == OP_RTYPE) || (op == OP_LOAD) || (op == OP_STORE) ||
                    (op == OP_BEQ) || (op == OP_JUMP);

  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RTYPE || op == OP_LOAD || op == OP_STORE) |=> dbg_pc == $past(seq_pc));

  a_r2_add_result: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RTYPE && fn == FN_ADD && dbg_wr_en) |-> dbg_wr_data == rs_val + rt_val);

  a_r3_slt_bool: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RTYPE && fn == FN_SLT && dbg_wr_en) |-> dbg_wr_data[31:1] == '0);

  a_r4_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STORE) |-> !dbg_wr_en);

  a_r5_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BEQ && rs_val == rt_val) |=> dbg_pc == $past(br_pc));

  a_r5_beq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BEQ && rs_val != rt_val) |=> dbg_pc == $past(seq_pc));

  a_r6_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JUMP) |=> dbg_pc == $past(jmp_pc));

  a_r7_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_en |-> dbg_wr_addr != 5'd0);

  a_r8_reset_pc: assert property (@(posedge clk)
    !rst_n |=> dbg_pc == 32'd0);

  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !known_op |-> (!dbg_wr_en ##1 dbg_pc == $past(seq_pc)));

endmodule

bind core_top core_checks i_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .dbg_pc      (dbg_pc),
  .dbg_wr_en   (dbg_wr_en),
  .dbg_wr_addr (dbg_wr_addr),
  .dbg_wr_data (dbg_wr_data),
  .instr       (instr),
  .rs_val      (rs_val),
  .rt_val      (rt_val)
);

// File: tb/test_core_top.sv
module test_core_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_we = 1'b0;
  logic        load_dmem = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_reg  [32];
  logic [31:0] m_dmem [64];
  logic [31:0] m_imem [64];
  logic [31:0] m_pc;

  always #4 clk = ~clk;

  core_top i_core_top (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .dbg_pc(dbg_pc),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] enc_j(input int word);
    return {6'h02, word[25:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic preload(input bit to_dmem, input int idx, input logic [31:0] word);
    @(negedge clk);
    load_we = 1'b1; load_dmem = to_dmem; load_addr = idx[5:0]; load_data = word;
    if (to_dmem) m_dmem[idx] = word; else m_imem[idx] = word;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  // reference model: expected write-port values for the current state, then commit
  task automatic model_step(output bit we, output logic [4:0] wa, output logic [31:0] wd,
                            output string tag);
    logic [31:0] ins, a, b, imm, npc, ea, res;
    bit ok;
    ins = m_imem[m_pc[7:2]];
    a   = m_reg[ins[25:21]];
    b   = m_reg[ins[20:16]];
    imm = {{16{ins[15]}}, ins[15:0]};
    npc = m_pc + 32'd4;
    we = 1'b0; wa = '0; wd = '0; tag = "R1";
    case (ins[31:26])
      6'h00: begin
        ok = 1'b1;
        case (ins[5:0])
          6'h20: begin res = a + b; tag = "R2"; end
          6'h22: begin res = a - b; tag = "R2"; end
          6'h24: begin res = a & b; tag = "R2"; end
          6'h25: begin res = a | b; tag = "R2"; end
          6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
          default: begin ok = 1'b0; res = '0; tag = "R10"; end
        endcase
        wa = ins[15:11]; wd = res;
        we = ok && (wa != 5'd0);
        if (ok && wa == 5'd0) tag = "R7";
      end
      6'h23: begin
        ea = a + imm; wa = ins[20:16]; wd = m_dmem[ea[7:2]];
        we = (wa != 5'd0); tag = "R4 R9";
      end
      6'h2B: begin
        ea = a + imm; m_dmem[ea[7:2]] = b; tag = "R4";
      end
      6'h04: begin
        if (a == b) npc = npc + {imm[29:0], 2'b00};
        tag = "R5";
      end
      6'h02: begin
        npc = {npc[31:28], ins[25:0], 2'b00}; tag = "R6";
      end
      default: tag = "R10";
    endcase
    if (we) m_reg[wa] = wd;
    m_pc = npc;
  endtask

  task automatic run_cycles(input int n);
    bit we; logic [4:0] wa; logic [31:0] wd; string tag; logic [31:0] exp_pc;
    for (int c = 0; c < n; c++) begin
      #1;
      exp_pc = m_pc;
      model_step(we, wa, wd, tag);
      check(dbg_pc == exp_pc, "R1", "pc", dbg_pc, exp_pc);
      check(dbg_wr_en == we, tag, "wr_en", {31'd0, dbg_wr_en}, {31'd0, we});
      if (we) begin
        check(dbg_wr_addr == wa, tag, "wr_addr", {27'd0, dbg_wr_addr}, {27'd0, wa});
        check(dbg_wr_data == wd, tag, "wr_data", dbg_wr_data, wd);
      end
      @(negedge clk);
    end
  endtask

  task automatic reset_core;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
  endtask

  task automatic release_and_check;
    @(negedge clk);
    #1;
    check(dbg_pc == 32'd0, "R8", "pc in reset", dbg_pc, 32'd0);
    check(!dbg_wr_en, "R8", "wr_en in reset", {31'd0, dbg_wr_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] rand_instr();
    int rs, rt, rd, k;
    logic [5:0] fns [5];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    rs = $urandom % 8; rt = $urandom % 8; rd = $urandom % 8;
    k = $urandom % 10;
    case (k)
      0, 1, 2: return enc_r(rs, rt, rd, fns[$urandom % 5]);
      3, 4:    return enc_i(6'h23, rs, rt, int'($urandom % 64) - 32);
      5:       return enc_i(6'h2B, rs, rt, int'($urandom % 64) - 32);
      6:       return enc_i(6'h04, rs, rt, int'($urandom % 16) - 8);
      7:       return enc_j($urandom % 64);
      8:       return enc_r(rs, rt, rd, 6'h3E);
      default: return {6'h3F, $urandom % (1 << 26)};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;

    // ---- directed program ----
    preload(1'b1, 0, 32'h8000_0005);
    preload(1'b1, 1, 32'h0000_0008);
    preload(1'b1, 2, 32'h1234_5678);
    for (int i = 3; i < 64; i++) preload(1'b1, i, $urandom);
    preload(1'b0, 0,  enc_i(6'h23, 0, 1, 0));        // lw r1,0(r0)
    preload(1'b0, 1,  enc_i(6'h23, 0, 2, 4));        // lw r2,4(r0)
    preload(1'b0, 2,  enc_i(6'h23, 0, 3, 8));        // lw r3,8(r0)
    preload(1'b0, 3,  enc_r(1, 2, 4, 6'h20));        // R2 add
    preload(1'b0, 4,  enc_r(2, 1, 5, 6'h22));        // R2 sub
    preload(1'b0, 5,  enc_r(1, 3, 6, 6'h24));        // R2 and
    preload(1'b0, 6,  enc_r(1, 3, 7, 6'h25));        // R2 or
    preload(1'b0, 7,  enc_r(1, 2, 8, 6'h2A));        // R3 negative < positive -> 1
    preload(1'b0, 8,  enc_r(2, 1, 9, 6'h2A));        // R3 -> 0
    preload(1'b0, 9,  enc_r(2, 2, 0, 6'h20));        // R7 write to r0 dropped
    preload(1'b0, 10, enc_r(0, 0, 10, 6'h25));       // R7 r0 reads zero
    preload(1'b0, 11, enc_i(6'h2B, 2, 3, 12));       // R4 sw r3,12(r2)
    preload(1'b0, 12, enc_i(6'h23, 2, 11, -4));      // R4 negative offset
    preload(1'b0, 13, enc_i(6'h23, 2, 12, 12));      // R4 read back store
    preload(1'b0, 14, enc_i(6'h04, 1, 2, 5));        // R5 not taken
    preload(1'b0, 15, enc_i(6'h04, 2, 11, 2));       // R5 taken -> word 18
    preload(1'b0, 16, enc_r(1, 1, 13, 6'h20));
    preload(1'b0, 17, enc_r(1, 1, 14, 6'h20));
    preload(1'b0, 18, enc_j(21));                    // R6
    preload(1'b0, 19, enc_r(1, 1, 15, 6'h20));
    preload(1'b0, 20, enc_r(1, 1, 16, 6'h20));
    preload(1'b0, 21, 32'hFC00_0000);                // R10 unknown opcode
    preload(1'b0, 22, enc_r(1, 2, 17, 6'h3E));       // R10 unknown function
    preload(1'b0, 23, enc_i(6'h04, 0, 0, -1));       // R5 self loop
    for (int i = 24; i < 64; i++) preload(1'b0, i, 32'd0);
    release_and_check();
    run_cycles(40);

    // ---- random programs ----
    for (int p = 0; p < 4; p++) begin
      reset_core();
      for (int i = 0; i < 64; i++) preload(1'b1, i, $urandom);
      for (int i = 0; i < 64; i++) preload(1'b0, i, rand_instr());
      release_and_check();
      run_cycles(300);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule